// File: doc/BRIEF.md
# Cartridge ROM Select and Boot Sequencer

This block sits between the CPU's ROM access path and two cartridge ports of up to 1 MiB each, together 2 MiB. It chooses whether the internal firmware ROM or a cartridge answers a ROM access. It drives the cartridge bank address lines and one active-low chip enable per port. It passes the CPU write strobe to the cartridge so that flash cartridges can be rewritten in place. It also drives the cartridge clear line.

After a cold reset the cartridges stay off and the internal firmware answers every ROM access. This gives firmware time to set up the I/O controller and the palette memory. Firmware then switches the ports on through a serial controller handshake line and asks for a warm reset. The sequencer gives one fixed-length clear pulse and then stays in cartridge mode. A later warm request never restarts the sequence, whether or not a cartridge is present. A second handshake line swaps the address ranges of the two ports.

The sequencer has four states. In COLD it holds the clear line for one cycle after reset and then moves to FIRMWARE. In FIRMWARE the internal ROM is mapped, and a warm request moves it to HANDOFF. In HANDOFF the clear pulse runs, and when the pulse counter expires the sequencer moves to CART. CART is terminal until the next cold reset.

Top module: `cart_boot_ctrl`

## Requirements
- R1: While cold reset is held low, and for the first cycle after its release (state COLD), `cart_clr_n` is low. During that time every ROM access goes to the internal ROM and both chip enables stay high.
- R2: In FIRMWARE, `int_rom_en` follows `rom_sel`, and `cart_ce_n` stays at 2'b11 whatever the handshake lines do. `cart_clr_n` is high.
- R3: A cycle with `fw_warm_req` high in FIRMWARE starts HANDOFF. `cart_clr_n` is then low for exactly CLR_CYCLES (16) cycles, after which the state is CART with `cart_clr_n` high.
- R4: In CART, `fw_warm_req` is ignored: `cart_clr_n` stays high and the mapping does not change.
- R5: The port-enable and swap settings are sampled from `hs_port_on` and `hs_port_swap` (active high) in FIRMWARE and CART. A warm hand-off keeps them, and only cold reset clears them.
- R6: In CART with the ports enabled, an access is a cycle with `rom_sel` high and `cpu_rd_n` or `cpu_wr_n` low. Such an access pulls `int_rom_en` low and exactly one chip enable low. The port index is bank bit 6 (address bit 20) XOR swap, and index 0 drives `cart_ce_n[0]`.
- R7: In CART with the ports disabled, ROM accesses go to the internal ROM and no chip enable is asserted.
- R8: `cart_bank` equals `bank_latch` when `bank_oe` is high and is all zeroes when `bank_oe` is low. Bank bit k carries cartridge address bit 14+k.
- R9: `cart_wr_n` follows `cpu_wr_n` only while a cartridge is active and `rom_sel` is high. Otherwise it is high.
- R10: With `rom_sel` low, `int_rom_en` is low and no chip enable is asserted. With `rom_sel` high but neither strobe low, no chip enable is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Cold reset, active low |
| fw_warm_req | input | 1 | Firmware request for the warm hand-off |
| hs_port_on | input | 1 | Serial handshake line: cartridge ports on |
| hs_port_swap | input | 1 | Serial handshake line: swap port ranges |
| bank_latch | input | 7 | ROM bank latch value |
| bank_oe | input | 1 | Bank latch output enable, active high |
| rom_sel | input | 1 | CPU ROM access select, active high |
| cpu_rd_n | input | 1 | CPU read strobe, active low |
| cpu_wr_n | input | 1 | CPU write strobe, active low |
| cart_bank | output | 7 | Cartridge bank address (address bits 20..14) |
| cart_ce_n | output | 2 | Per-port chip enables, active low |
| int_rom_en | output | 1 | Internal ROM enable, active high |
| cart_wr_n | output | 1 | Write strobe on the cartridge supply-pin position |
| cart_clr_n | output | 1 | Clear line to the cartridge, active low |

## Verification
The bench builds the block with its defaults: seven bank bits, two ports and a 16-cycle clear pulse. With seven bank bits, one bank latch value reaches either port, with and without swap. A 16-cycle pulse is short enough that every cycle of HANDOFF is checked. Two cold resets bring both settings of the sticky enable into CART, and warm requests are repeated in CART to show that no second pulse appears.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    typedef enum logic [1:0] {
        ST_COLD     = 2'd0,
        ST_FIRMWARE = 2'd1,
        ST_HANDOFF  = 2'd2,
        ST_CART     = 2'd3
    } boot_state_t;
endpackage

// File: rtl/cbs_seq.sv
module cbs_seq
    import cbs_pkg::*;
#(
    parameter int CLR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic warm_req,
    input  logic hs_on,
    input  logic hs_swap,
    output logic cart_on,
    output logic swap_q,
    output logic clr_n
);
    localparam int CNT_W = (CLR_CYCLES > 1) ? $clog2(CLR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CLR_CYCLES - 1);

    boot_state_t state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic en_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_COLD;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLD:     state_nx = ST_FIRMWARE;
            ST_FIRMWARE: if (warm_req) state_nx = ST_HANDOFF;
            ST_HANDOFF:  if (cnt == LAST) state_nx = ST_CART;
            ST_CART:     state_nx = ST_CART;
            default:     state_nx = ST_COLD;
        endcase
    end

    // pulse length counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (state == ST_HANDOFF) cnt <= cnt + 1'b1;
        else                         cnt <= '0;
    end

    // sticky settings: only cold reset clears them
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            swap_q <= 1'b0;
        end else if (state == ST_FIRMWARE || state == ST_CART) begin
            en_q   <= hs_on;
            swap_q <= hs_swap;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_COLD:     begin clr_n = 1'b0; cart_on = 1'b0; end
            ST_FIRMWARE: begin clr_n = 1'b1; cart_on = 1'b0; end
            ST_HANDOFF:  begin clr_n = 1'b0; cart_on = 1'b0; end
            ST_CART:     begin clr_n = 1'b1; cart_on = en_q; end
            default:     begin clr_n = 1'b0; cart_on = 1'b0; end
        endcase
    end

    p_cold_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COLD |=> state == ST_FIRMWARE);
    p_fw_internal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_FIRMWARE |-> !cart_on && clr_n);
    p_handoff_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANDOFF && cnt == LAST) |=> state == ST_CART);
    p_cart_stays_r4: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_CART |=> state == ST_CART && clr_n);
endmodule

// File: rtl/cbs_map.sv
module cbs_map #(
    parameter int BANK_W  = 7,
    parameter int N_PORTS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cart_act,
    input  logic              swap,
    input  logic              bank_oe,
    input  logic [BANK_W-1:0] bank_latch,
    input  logic              rom_sel,
    input  logic              rd_n,
    input  logic              wr_n,
    output logic [BANK_W-1:0] cart_bank,
    output logic [N_PORTS-1:0] ce_n,
    output logic              int_en,
    output logic              cart_wr_n
);
    localparam int PSEL_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [PSEL_W-1:0] port_idx;
    logic strobe;

    always_comb begin
        cart_bank = bank_oe ? bank_latch : '0;
        port_idx  = cart_bank[BANK_W-1 -: PSEL_W] ^ {PSEL_W{swap}};
        strobe    = rom_sel && (!rd_n || !wr_n);
        int_en    = rom_sel && !cart_act;
        cart_wr_n = !(cart_act && rom_sel && !wr_n);
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign ce_n[p] = !(cart_act && strobe && port_idx == PSEL_W'(p));
    end

    p_one_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));
    p_int_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(&ce_n) |-> !int_en);
    p_idle_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cart_act |-> cart_wr_n);
    p_no_sel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_sel |-> (&ce_n) && !int_en);
endmodule

// File: rtl/cart_boot_ctrl.sv
module cart_boot_ctrl #(
    parameter int BANK_W     = 7,
    parameter int N_PORTS    = 2,
    parameter int CLR_CYCLES = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fw_warm_req,
    input  logic               hs_port_on,
    input  logic               hs_port_swap,
    input  logic [BANK_W-1:0]  bank_latch,
    input  logic               bank_oe,
    input  logic               rom_sel,
    input  logic               cpu_rd_n,
    input  logic               cpu_wr_n,
    output logic [BANK_W-1:0]  cart_bank,
    output logic [N_PORTS-1:0] cart_ce_n,
    output logic               int_rom_en,
    output logic               cart_wr_n,
    output logic               cart_clr_n
);
    logic cart_on, swap_q;

    cbs_seq #(.CLR_CYCLES(CLR_CYCLES)) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .warm_req (fw_warm_req),
        .hs_on    (hs_port_on),
        .hs_swap  (hs_port_swap),
        .cart_on  (cart_on),
        .swap_q   (swap_q),
        .clr_n    (cart_clr_n)
    );

    cbs_map #(.BANK_W(BANK_W), .N_PORTS(N_PORTS)) i_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .cart_act   (cart_on),
        .swap       (swap_q),
        .bank_oe    (bank_oe),
        .bank_latch (bank_latch),
        .rom_sel    (rom_sel),
        .rd_n       (cpu_rd_n),
        .wr_n       (cpu_wr_n),
        .cart_bank  (cart_bank),
        .ce_n       (cart_ce_n),
        .int_en     (int_rom_en),
        .cart_wr_n  (cart_wr_n)
    );
endmodule

// File: tb/test_cart_boot_ctrl.sv
`timescale 1ns/1ps
module test_cart_boot_ctrl;
    logic clk = 1'b0;
    logic rst_n, fw_warm_req, hs_port_on, hs_port_swap;
    logic [6:0] bank_latch;
    logic bank_oe, rom_sel, cpu_rd_n, cpu_wr_n;
    logic [6:0] cart_bank;
    logic [1:0] cart_ce_n;
    logic int_rom_en, cart_wr_n, cart_clr_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    typedef struct {
        string      tag;
        logic       int_en;
        logic [1:0] ce_n;
        logic [6:0] bank;
        logic       wr_n;
        logic       clr_n;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    cart_boot_ctrl i_cart_boot_ctrl (
        .clk(clk), .rst_n(rst_n), .fw_warm_req(fw_warm_req),
        .hs_port_on(hs_port_on), .hs_port_swap(hs_port_swap),
        .bank_latch(bank_latch), .bank_oe(bank_oe), .rom_sel(rom_sel),
        .cpu_rd_n(cpu_rd_n), .cpu_wr_n(cpu_wr_n), .cart_bank(cart_bank),
        .cart_ce_n(cart_ce_n), .int_rom_en(int_rom_en),
        .cart_wr_n(cart_wr_n), .cart_clr_n(cart_clr_n)
    );

    task automatic drive(input logic oe, input logic [6:0] lat,
                         input logic sel, input logic rd, input logic wr);
        bank_oe = oe; bank_latch = lat; rom_sel = sel; cpu_rd_n = rd; cpu_wr_n = wr;
    endtask

    task automatic expect_now(input string tag, input logic ie, input logic [1:0] ce,
                              input logic [6:0] bk, input logic wr, input logic clr);
        exp_t e;
        e.tag = tag; e.int_en = ie; e.ce_n = ce; e.bank = bk; e.wr_n = wr; e.clr_n = clr;
        q.push_back(e);
    endtask

    // monitor: compare away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_checks++;
                if ({int_rom_en, cart_ce_n, cart_bank, cart_wr_n, cart_clr_n} !==
                    {e.int_en, e.ce_n, e.bank, e.wr_n, e.clr_n}) begin
                    n_fail++;
                    $display("FAIL %s: got int=%b ce=%b bank=%h wr=%b clr=%b exp int=%b ce=%b bank=%h wr=%b clr=%b",
                             e.tag, int_rom_en, cart_ce_n, cart_bank, cart_wr_n, cart_clr_n,
                             e.int_en, e.ce_n, e.bank, e.wr_n, e.clr_n);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got no end exp end");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; fw_warm_req = 0; hs_port_on = 0; hs_port_swap = 0;
        drive(1, 7'h45, 1, 0, 1);
        repeat (3) @(negedge clk);
        expect_now("R1 reset held", 1, 2'b11, 7'h45, 1, 0);
        @(negedge clk); rst_n = 1;
        expect_now("R1 COLD cycle", 1, 2'b11, 7'h45, 1, 0);
        @(negedge clk); hs_port_on = 1;
        expect_now("R2 FIRMWARE read", 1, 2'b11, 7'h45, 1, 1);
        @(negedge clk); drive(1, 7'h45, 1, 1, 0);
        expect_now("R9 FIRMWARE write", 1, 2'b11, 7'h45, 1, 1);
        @(negedge clk); drive(0, 7'h55, 1, 0, 1);
        expect_now("R8 oe low", 1, 2'b11, 7'h00, 1, 1);
        @(negedge clk); drive(1, 7'h55, 1, 0, 1);
        expect_now("R8 oe high", 1, 2'b11, 7'h55, 1, 1);
        @(negedge clk); fw_warm_req = 1;
        expect_now("R2 before request", 1, 2'b11, 7'h55, 1, 1);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); fw_warm_req = 0;
            expect_now($sformatf("R3 pulse cycle %0d", i), 1, 2'b11, 7'h55, 1, 0);
        end
        @(negedge clk);
        expect_now("R3 CART after pulse / R5 kept", 0, 2'b01, 7'h55, 1, 1);
        @(negedge clk); drive(1, 7'h05, 1, 0, 1);
        expect_now("R6 port0", 0, 2'b10, 7'h05, 1, 1);
        @(negedge clk); drive(1, 7'h05, 1, 1, 0);
        expect_now("R9 cart write", 0, 2'b10, 7'h05, 0, 1);
        @(negedge clk); drive(1, 7'h05, 1, 0, 1); hs_port_swap = 1;
        @(negedge clk);
        expect_now("R6 swapped low bank", 0, 2'b01, 7'h05, 1, 1);
        @(negedge clk); drive(1, 7'h45, 1, 0, 1);
        expect_now("R6 swapped high bank", 0, 2'b10, 7'h45, 1, 1);
        @(negedge clk); fw_warm_req = 1;
        expect_now("R4 request in CART", 0, 2'b10, 7'h45, 1, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); fw_warm_req = (i < 3);
            expect_now("R4 no second pulse", 0, 2'b10, 7'h45, 1, 1);
        end
        @(negedge clk); drive(1, 7'h45, 0, 0, 1);
        expect_now("R10 no rom_sel", 0, 2'b11, 7'h45, 1, 1);
        @(negedge clk); drive(1, 7'h45, 1, 1, 1);
        expect_now("R10 no strobe", 0, 2'b11, 7'h45, 1, 1);
        @(negedge clk); drive(1, 7'h45, 1, 0, 1); hs_port_on = 0;
        @(negedge clk);
        expect_now("R7 ports off", 1, 2'b11, 7'h45, 1, 1);
        @(negedge clk); rst_n = 0; hs_port_swap = 0;
        expect_now("R1 second cold reset", 1, 2'b11, 7'h45, 1, 0);
        @(negedge clk); rst_n = 1;
        @(negedge clk); fw_warm_req = 1;
        @(negedge clk); fw_warm_req = 0;
        repeat (16) @(negedge clk);
        drive(1, 7'h05, 1, 0, 1);
        expect_now("R5 cleared by cold reset", 1, 2'b11, 7'h05, 1, 1);
        @(negedge clk); hs_port_on = 1;
        @(negedge clk);
        expect_now("R5 enable sampled in CART", 0, 2'b10, 7'h05, 1, 1);
        repeat (2) @(negedge clk);
        #2;
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule